// File: doc/BRIEF.md
# Keyed One-Shot Watchdog Timer

This block is a hardware watchdog that sits dormant after a system reset and does nothing until software writes a fixed two-byte key to its service register. The first complete key starts it. From then on it counts peripheral clock ticks, first through a selectable power-of-two prescaler and then through a 14-bit main counter. Only a system reset stops it again. Each later complete key clears both the prescaler and the main counter, which restarts the timeout window.

If the main counter overflows, the block raises a one-cycle internal reset request and drives a reset-out pulse 96 clock cycles wide. After the pulse it goes back to the dormant state and waits for a new key. The block keeps counting while the processor idles, so software has to wake up often enough to service it. It freezes while power-down is indicated, because the clock is stopped then. The service register can only be written.

Top module: `wdg_keyed`

## Requirements
- R1: After reset, `rst_out` and `rst_req` are low and stay low, whatever ticks arrive, until a valid key has been written.
- R2: A write of 8'h1E to the service register (`wr_sel`=0) followed directly by a write of 8'hE1 to it starts the watchdog. With divide select 0 and a tick on every cycle, `rst_out` rises exactly 16384 clock edges after the edge that takes the 8'hE1 write.
- R3: A service-register write other than 8'hE1 right after 8'h1E breaks the key. Neither the broken sequence nor a lone 8'hE1 changes the count or starts the watchdog. Each write of 8'h1E arms the detector again.
- R4: A complete key written while the watchdog runs clears the prescaler and the main counter, so the timeout comes 16384 x 2^sel counted ticks after that key.
- R5: Once running, the watchdog cannot be stopped by any register write. Only the system reset `rst_n` stops it.
- R6: Bits [2:0] of a write to the program register (`wr_sel`=1) select a prescale ratio of 2^sel (1 to 128). Bits [7:3] are ignored. The timeout is 16384 x 2^sel counted ticks.
- R7: A tick is counted only on a cycle where `tick_en` is high and `pwr_down` is low. `idle` has no effect on counting.
- R8: On timeout, `rst_req` is high for exactly one cycle. `rst_out` rises in the same cycle and stays high for exactly 96 cycles.
- R9: After the pulse the watchdog is dormant again. Key writes made during the pulse are ignored, so nothing more is counted until a new key arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 service register, 1 program register |
| wr_data | input | 8 | Write data |
| tick_en | input | 1 | Peripheral clock enable; one tick per high cycle |
| idle | input | 1 | Processor idle indication (no effect on counting) |
| pwr_down | input | 1 | Power-down indication; freezes counting |
| rst_req | output | 1 | One-cycle internal reset request on timeout |
| rst_out | output | 1 | Reset-out pulse, 96 cycles |

## Verification
The bench finds the exact timeout edge by checking `rst_out` one cycle before and on the expected edge. An off-by-one in the counter or prescaler, or a prescaler that is not cleared at enable, therefore shows up as a miscompare. Broken and partial keys are sent both before and after enabling. A detector that accepts a lone 8'hE1, or that does not reset on a wrong byte, would start the watchdog or move its timeout. A power-down and tick gap in the middle of a run checks the freeze, since a design that counted through it would fire 1500 cycles early. A key written during the reset-out pulse, followed by a long quiet window, catches a design that re-arms itself or accepts keys while firing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      WDG_OFF  = 2'd0,
      WDG_RUN  = 2'd1,
      WDG_FIRE = 2'd2
   } wdg_state_e;
endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq #(
   parameter int unsigned DW    = 8,
   parameter logic [DW-1:0] KEY_A = 8'h1E,
   parameter logic [DW-1:0] KEY_B = 8'hE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   input  logic          block,
   output logic          key_hit
);
   generate
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("wdg_key_seq: the two key bytes must differ");
      end
   endgenerate

   logic armed;
   logic stb_ok;

   assign stb_ok  = wr_stb && !block;
   assign key_hit = stb_ok && armed && (wr_data == KEY_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (block)  armed <= 1'b0;
      else if (stb_ok) armed <= (wr_data == KEY_A);
   end

   // R3
   hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> !armed);

   // R3
   wrong_byte_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_ok && wr_data != KEY_A) |=> !armed);
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int unsigned SEL_W  = 3,
   parameter bit          PRE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SEL_W-1:0] sel,
   output logic             strobe
);
   localparam int unsigned PRE_W = (1 << SEL_W) - 1;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("wdg_prescaler: SEL_W must be 1..4");
      end

      if (PRE_EN) begin : g_div
         logic [PRE_W-1:0] pre_cnt;
         logic [PRE_W-1:0] mask;

         assign mask   = ~({PRE_W{1'b1}} << sel);
         assign strobe = adv && ((pre_cnt & mask) == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_cnt <= '0;
            else if (clr) pre_cnt <= '0;
            else if (adv) pre_cnt <= pre_cnt + 1'b1;
         end

         // R6
         div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && sel == '0) |-> strobe);
      end else begin : g_nodiv
         logic [SEL_W-1:0] sel_unused;
         assign sel_unused = sel;
         assign strobe     = adv;
      end
   endgenerate

   // R7
   no_adv_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |-> !strobe);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W     = 14,
   parameter int unsigned PULSE_LEN = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_hit,
   input  logic strobe,
   output logic running,
   output logic firing,
   output logic clr_pre,
   output logic rst_req,
   output logic rst_out
);
   localparam int unsigned PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("wdg_core: CNT_W must be at least 2");
      end
      if (PULSE_LEN < 2) begin : g_bad_pulse
         $error("wdg_core: PULSE_LEN must be at least 2");
      end
   endgenerate

   wdg_state_e       state;
   logic [CNT_W-1:0] count;
   logic [PW-1:0]    pcnt;
   logic             timeout;

   assign running = (state == WDG_RUN);
   assign firing  = (state == WDG_FIRE);
   assign timeout = running && strobe && (&count) && !key_hit;
   assign clr_pre = key_hit || !running;
   assign rst_out = firing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WDG_OFF;
         count   <= '0;
         pcnt    <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= timeout;
         unique case (state)
            WDG_OFF: begin
               count <= '0;
               if (key_hit) state <= WDG_RUN;
            end
            WDG_RUN: begin
               if (key_hit) begin
                  count <= '0;
               end else if (timeout) begin
                  state <= WDG_FIRE;
                  count <= '0;
                  pcnt  <= '0;
               end else if (strobe) begin
                  count <= count + 1'b1;
               end
            end
            WDG_FIRE: begin
               if (pcnt == PW'(PULSE_LEN - 1)) state <= WDG_OFF;
               else                            pcnt  <= pcnt + 1'b1;
            end
            default: state <= WDG_OFF;
         endcase
      end
   end

   // R1
   off_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WDG_OFF) |-> (count == '0));

   // R5
   no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !(strobe && (&count))) |=> running);

   // R7
   hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !strobe && !key_hit) |=> $stable(count));

   // R8
   req_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> rst_out);

   // R8
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R9
   pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out) |-> (state == WDG_OFF && $past(pcnt) == PW'(PULSE_LEN - 1)));
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed #(
   parameter int unsigned DW        = 8,
   parameter int unsigned CNT_W     = 14,
   parameter int unsigned SEL_W     = 3,
   parameter bit          PRE_EN    = 1'b1,
   parameter int unsigned PULSE_LEN = 96,
   parameter logic [DW-1:0] KEY_A   = 8'h1E,
   parameter logic [DW-1:0] KEY_B   = 8'hE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          tick_en,
   input  logic          idle,
   input  logic          pwr_down,
   output logic          rst_req,
   output logic          rst_out
);
   generate
      if (SEL_W > DW) begin : g_bad_width
         $error("wdg_keyed: SEL_W cannot exceed DW");
      end
   endgenerate

   logic             idle_unused;
   logic [SEL_W-1:0] sel_q;
   logic             key_hit;
   logic             running;
   logic             firing;
   logic             clr_pre;
   logic             adv;
   logic             strobe;

   assign idle_unused = idle;
   assign adv         = running && tick_en && !pwr_down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sel_q <= '0;
      else if (wr_en && wr_sel)  sel_q <= wr_data[SEL_W-1:0];
   end

   wdg_key_seq #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_en && !wr_sel),
      .wr_data (wr_data),
      .block   (firing),
      .key_hit (key_hit)
   );

   wdg_prescaler #(.SEL_W(SEL_W), .PRE_EN(PRE_EN)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_pre),
      .adv    (adv),
      .sel    (sel_q),
      .strobe (strobe)
   );

   wdg_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_hit (key_hit),
      .strobe  (strobe),
      .running (running),
      .firing  (firing),
      .clr_pre (clr_pre),
      .rst_req (rst_req),
      .rst_out (rst_out)
   );

   // R7
   pd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down || !tick_en) |-> !strobe);

   // R9
   fire_ignores_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      firing |-> !key_hit);
endmodule

// File: tb/tb_wdg_keyed.sv
module tb_wdg_keyed;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tick_en = 1'b1;
   logic       idle = 1'b0;
   logic       pwr_down = 1'b0;
   logic       rst_req;
   logic       rst_out;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   wdg_keyed dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tick_en(tick_en), .idle(idle),
      .pwr_down(pwr_down), .rst_req(rst_req), .rst_out(rst_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic enable_key();
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'hE1);
   endtask

   task automatic watch_quiet(input int n, input string req);
      logic seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (rst_out || rst_req) seen = 1'b1;
      end
      check(req, seen, 1'b0);
   endtask

   // R1 and R3: dormant after reset, broken keys do not start it
   task automatic t_dormant();
      do_reset();
      check("R1 rst_out after reset", rst_out, 1'b0);
      check("R1 rst_req after reset", rst_req, 1'b0);
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'h55);
      wr(1'b0, 8'hE1);
      wr(1'b0, 8'hE1);
      watch_quiet(17000, "R3 broken key must not enable (R1 dormant)");
   endtask

   // R2, R7 (idle), R8, R9
   task automatic t_basic();
      do_reset();
      idle = 1'b1;
      enable_key();
      step(16383);
      check("R2 no timeout one edge early", rst_out, 1'b0);
      check("R8 no request one edge early", rst_req, 1'b0);
      step(1);
      check("R2 timeout edge, R7 idle counts", rst_out, 1'b1);
      check("R8 request on timeout edge", rst_req, 1'b1);
      wr(1'b0, 8'h1E);
      check("R8 request lasts one cycle", rst_req, 1'b0);
      wr(1'b0, 8'hE1);
      step(93);
      check("R8 pulse still high at cycle 96", rst_out, 1'b1);
      step(1);
      check("R8 pulse low after 96 cycles", rst_out, 1'b0);
      idle = 1'b0;
      watch_quiet(17000, "R9 dormant after pulse, key in pulse ignored");
   endtask

   // R3, R5: wrong sequences while running neither clear nor stop
   task automatic t_wrong_running();
      do_reset();
      enable_key();
      step(5000);
      wr(1'b0, 8'h1E);
      wr(1'b0, 8'h00);
      wr(1'b0, 8'hE1);
      wr(1'b0, 8'hE1);
      step(11379);
      check("R3 broken key keeps count (early)", rst_out, 1'b0);
      step(1);
      check("R5 still running, timeout on time", rst_out, 1'b1);
      step(100);
   endtask

   // R4: a full key restarts the window
   task automatic t_service();
      do_reset();
      enable_key();
      step(10000);
      enable_key();
      step(16383);
      check("R4 restarted window, one edge early", rst_out, 1'b0);
      step(1);
      check("R4 timeout after restart", rst_out, 1'b1);
      step(100);
   endtask

   // R7: power-down and missing ticks freeze counting
   task automatic t_freeze();
      do_reset();
      enable_key();
      step(100);
      pwr_down = 1'b1;
      step(1000);
      pwr_down = 1'b0;
      tick_en = 1'b0;
      step(500);
      tick_en = 1'b1;
      step(16283);
      check("R7 frozen cycles not counted (early)", rst_out, 1'b0);
      step(1);
      check("R7 timeout shifted by frozen cycles", rst_out, 1'b1);
      step(100);
   endtask

   // R6: prescale select from bits [2:0] only
   task automatic t_prescale();
      do_reset();
      wr(1'b1, 8'hF9);
      enable_key();
      step(32767);
      check("R6 divide by 2, one edge early", rst_out, 1'b0);
      step(1);
      check("R6 divide by 2 timeout", rst_out, 1'b1);
      step(100);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_dormant();
      t_basic();
      t_wrong_running();
      t_service();
      t_freeze();
      t_prescale();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule